// File: doc/BRIEF.md
# Auxiliary DAC Code Controller with Synchronized Updates

This block sits behind a decoded register write port and owns the settings for three 8-bit auxiliary converter channels (A, B, C). Every channel keeps two registers. The staged code is the value most recently written. The output code is the value driven to the converter. A code moves from the staged register to the output in one of three ways: at once when it is written, when software issues a one-shot update command while slave mode is on, or on a rising edge of the transmit power-down input. The third path lets all three channels change in step with the transmit chain coming up.

Other register bits turn on each channel's converter, choose which channels follow the transmit edge, and switch slave mode on and off. A combinational read port returns the staged codes and the control settings. The output codes come out of the block directly so that they can be observed.

Register addresses:
- 0, 1, 2: codes for A, B, C.
- 3: control. Bit 7 is slave enable. Bits 0, 1, 2 are the one-shot updates for A, B, C.
- 4: sync select. Bits 5, 6, 7 are for A, B, C.
- 5: power-up. Bits 0, 1, 2 are for A, B, C.
- 6 and 7: unmapped.

Top module: `auxdac_sync_ctrl`

## Requirements
- R1: During and after reset, all output codes are 0, all enables are 0, and every register reads back 0.
- R2: A read of address 0, 1 or 2 returns the staged code last written to that channel. Codes are straight binary.
- R3: When slave enable is 0 and a channel's sync bit is 0, a write to that channel's code address shows up on its output code one clock after the write edge.
- R4: When slave enable is 1, a code write changes only the staged code and leaves the output code unchanged.
- R5: When slave enable is 1, writing address 3 with bit k set copies the staged code of channel k to its output (k = 0 for A, 1 for B, 2 for C). Channels whose bit is clear keep their outputs.
- R6: A read of address 3 returns slave enable in bit 7. The update bits always read as 0.
- R7: A write of update bits while slave enable is 0 has no effect on any output code.
- R8: A channel whose sync bit is 1 (address 4, bit 5 for A, bit 6 for B, bit 7 for C) ignores both immediate writes and one-shot updates.
- R9: A rising edge of the transmit power-down input passes through two synchronizer flops. The output codes of all synced channels then take their staged codes on the third clock edge after the input rises. Holding the input high, or letting it fall, transfers nothing.
- R10: Address 5 bits 0, 1, 2 drive the enables of A, B, C and read back in the same positions. Bits 3 to 7 are ignored and read back as 0.
- R11: If a one-shot update and a transmit edge arrive in the same cycle, a synced channel takes its staged code once and a non-synced selected channel takes its staged code once.
- R12: Writes to unmapped addresses 6 and 7 change nothing, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe from the register decoder |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Combinational read data |
| txPwrDown | input | 1 | Asynchronous transmit power-down level |
| dacCode | output | 24 | Output codes: A in bits 7:0, B in 15:8, C in 23:16 |
| dacEnable | output | 3 | Converter enables: A in bit 0, B in bit 1, C in bit 2 |

## Verification
The bound checker watches the following on every cycle:
- the reset values;
- immediate transfer of a written code when slave mode and sync are both off;
- output codes holding still under slave-mode code writes;
- update bits reading as zero;
- enables following the power-up register;
- output codes changing only after a load strobe from the control half.

Some behaviour can only be shown by the bench's scenarios:
- the exact three-edge latency of the transmit synchronizer;
- no repeated transfer while the input is held high, and none on its falling edge;
- the case where a one-shot update and a transmit edge land in the same cycle;
- staged values that diverge from the outputs and are later released by an update.

// File: rtl/auxdac_pkg.sv
package auxdac_pkg;
  localparam int CH_N     = 3;
  localparam int CODE_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int SYNC_LSB = 5;
  localparam int SLAVE_BIT = 7;
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_SYNC = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADR_PWR  = ADDR_W'(5);

  // Strobes from control to datapath, one bit per channel
  typedef struct packed {
    logic [CH_N-1:0]   stageWe;    // write staged code from wrCode
    logic [CH_N-1:0]   immLoad;    // load output from wrCode
    logic [CH_N-1:0]   stagedLoad; // load output from staged code
    logic [CODE_W-1:0] wrCode;
  } strobe_t;
endpackage

// File: rtl/auxdac_ctrl.sv
module auxdac_ctrl
  import auxdac_pkg::*;
#(
  parameter int SYNC_FF = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic                   txPwrDown,
  input  logic [CH_N*CODE_W-1:0] stagedCodes,
  output strobe_t                strb,
  output logic [DATA_W-1:0]      rdData,
  output logic [CH_N-1:0]        pwrEn
);
  logic                slaveEn;
  logic [CH_N-1:0]     syncSel;
  logic [CH_N-1:0]     pwrUp;
  logic [SYNC_FF-1:0]  txSync;
  logic                txPrev;
  logic                txEdge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slaveEn <= 1'b0;
      syncSel <= '0;
      pwrUp   <= '0;
      txSync  <= '0;
      txPrev  <= 1'b0;
    end else begin
      txSync <= {txSync[SYNC_FF-2:0], txPwrDown};
      txPrev <= txSync[SYNC_FF-1];
      if (wrEn) begin
        case (wrAddr)
          ADR_CTRL: slaveEn <= wrData[SLAVE_BIT];
          ADR_SYNC: syncSel <= wrData[SYNC_LSB +: CH_N];
          ADR_PWR:  pwrUp   <= wrData[CH_N-1:0];
          default: ;
        endcase
      end
    end
  end

  assign txEdge = txSync[SYNC_FF-1] & ~txPrev;
  assign pwrEn  = pwrUp;

  always_comb begin
    strb.wrCode = wrData[CODE_W-1:0];
    for (int i = 0; i < CH_N; i++) begin
      strb.stageWe[i]    = wrEn && (wrAddr == ADDR_W'(i));
      strb.immLoad[i]    = strb.stageWe[i] && !slaveEn && !syncSel[i];
      strb.stagedLoad[i] = (wrEn && (wrAddr == ADR_CTRL) && slaveEn && wrData[i] && !syncSel[i])
                         || (txEdge && syncSel[i]);
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr < ADDR_W'(CH_N)) begin
      rdData[CODE_W-1:0] = stagedCodes[rdAddr*CODE_W +: CODE_W];
    end else begin
      case (rdAddr)
        ADR_CTRL: rdData[SLAVE_BIT] = slaveEn;
        ADR_SYNC: rdData[SYNC_LSB +: CH_N] = syncSel;
        ADR_PWR:  rdData[CH_N-1:0] = pwrUp;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/auxdac_dp.sv
module auxdac_dp
  import auxdac_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobe_t                strb,
  output logic [CH_N*CODE_W-1:0] stagedCodes,
  output logic [CH_N*CODE_W-1:0] outCodes
);
  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic [CODE_W-1:0] staged;
    logic [CODE_W-1:0] outQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged <= '0;
        outQ   <= '0;
      end else begin
        if (strb.stageWe[g]) staged <= strb.wrCode;
        if (strb.immLoad[g])         outQ <= strb.wrCode;
        else if (strb.stagedLoad[g]) outQ <= staged;
      end
    end
    assign stagedCodes[g*CODE_W +: CODE_W] = staged;
    assign outCodes[g*CODE_W +: CODE_W]    = outQ;
  end
endmodule

// File: rtl/auxdac_sync_ctrl.sv
module auxdac_sync_ctrl
  import auxdac_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [DATA_W-1:0]      rdData,
  input  logic                   txPwrDown,
  output logic [CH_N*CODE_W-1:0] dacCode,
  output logic [CH_N-1:0]        dacEnable
);
  strobe_t                strb;
  logic [CH_N*CODE_W-1:0] stagedCodes;

  auxdac_ctrl #(.SYNC_FF(2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .txPwrDown(txPwrDown), .stagedCodes(stagedCodes),
    .strb(strb), .rdData(rdData), .pwrEn(dacEnable)
  );

  auxdac_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .stagedCodes(stagedCodes), .outCodes(dacCode)
  );
endmodule

// File: rtl/auxdac_sync_ctrl_chk.sv
module auxdac_sync_ctrl_chk
  import auxdac_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      wrAddr,
  input logic [DATA_W-1:0]      wrData,
  input logic [ADDR_W-1:0]      rdAddr,
  input logic [DATA_W-1:0]      rdData,
  input logic [CH_N*CODE_W-1:0] dacCode,
  input logic [CH_N-1:0]        dacEnable,
  input strobe_t                strb
);
  logic            slaveSh;
  logic [CH_N-1:0] syncSh;
  logic [CH_N-1:0] pwrSh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slaveSh <= 1'b0; syncSh <= '0; pwrSh <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADR_CTRL) slaveSh <= wrData[SLAVE_BIT];
      if (wrAddr == ADR_SYNC) syncSh  <= wrData[SYNC_LSB +: CH_N];
      if (wrAddr == ADR_PWR)  pwrSh   <= wrData[CH_N-1:0];
    end
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (dacCode == '0) && (dacEnable == '0));

  assert_upd_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr == ADR_CTRL) |-> (rdData[CH_N-1:0] == '0));

  assert_enable_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dacEnable == pwrSh);

  assert_change_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dacCode) |-> $past(|(strb.immLoad | strb.stagedLoad)));

  for (genvar g = 0; g < CH_N; g++) begin : g_chan
    assert_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && wrAddr == ADDR_W'(g) && !slaveSh && !syncSh[g])
      |=> dacCode[g*CODE_W +: CODE_W] == $past(wrData[CODE_W-1:0]));

    assert_slave_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && wrAddr == ADDR_W'(g) && slaveSh && !syncSh[g])
      |=> $stable(dacCode[g*CODE_W +: CODE_W]));
  end
endmodule

bind auxdac_sync_ctrl auxdac_sync_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .dacCode(dacCode), .dacEnable(dacEnable),
  .strb(strb)
);

// File: tb/auxdac_sync_ctrl_bench.sv
`timescale 1ns/1ps
module auxdac_sync_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        txPwrDown = 1'b0;
  logic [23:0] dacCode;
  logic [2:0]  dacEnable;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  auxdac_sync_ctrl u_auxdac_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .txPwrDown(txPwrDown),
    .dacCode(dacCode), .dacEnable(dacEnable)
  );

  typedef struct packed {
    logic [2:0]  a;
    logic [7:0]  d;
    logic [23:0] e;   // expected {C,B,A}
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'h12, 24'h000012},  // R3
    '{3'd1, 8'hFF, 24'h00FF12},  // R3
    '{3'd2, 8'h80, 24'h80FF12},  // R3
    '{3'd0, 8'h00, 24'h80FF00},  // R3
    '{3'd3, 8'h80, 24'h80FF00},  // slave on
    '{3'd0, 8'h55, 24'h80FF00},  // R4
    '{3'd1, 8'h66, 24'h80FF00},  // R4
    '{3'd3, 8'h81, 24'h80FF55},  // R5 update A
    '{3'd3, 8'h86, 24'h806655},  // R5 update B,C
    '{3'd3, 8'h00, 24'h806655},  // slave off
    '{3'd4, 8'h20, 24'h806655},  // sync A
    '{3'd0, 8'h21, 24'h806655},  // R8 immediate ignored
    '{3'd4, 8'h00, 24'h806655},  // sync off
    '{3'd3, 8'h07, 24'h806655},  // R7 update without slave
    '{3'd3, 8'h80, 24'h806655},  // slave on
    '{3'd3, 8'h81, 24'h806621},  // R5 releases staged A
    '{3'd3, 8'h00, 24'h806621}   // slave off
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    rdAddr = a;
    #0.1;
    check(tag, {24'h0, rdData}, {24'h0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, during reset
    check("R1 code in reset", {8'h0, dacCode}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code", {8'h0, dacCode}, 32'h0);
    check("R1 enable", {29'h0, dacEnable}, 32'h0);
    for (int a = 0; a < 8; a++) rd("R1 readback", 3'(a), 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].d);
      check($sformatf("R3/R4/R5/R7/R8 vector %0d", i), {8'h0, dacCode}, {8'h0, VECS[i].e});
    end

    // R2 staged readback
    rd("R2 A", 3'd0, 8'h21);
    rd("R2 B", 3'd1, 8'h66);
    rd("R2 C", 3'd2, 8'h80);
    // R6 control readback
    wr(3'd3, 8'h87);
    rd("R6 ctrl", 3'd3, 8'h80);
    wr(3'd3, 8'h00);
    rd("R6 ctrl off", 3'd3, 8'h00);

    // R10 power bits
    wr(3'd5, 8'h05);
    check("R10 en", {29'h0, dacEnable}, 32'h5);
    rd("R10 read", 3'd5, 8'h05);
    wr(3'd5, 8'hFA);
    check("R10 upper ignored", {29'h0, dacEnable}, 32'h2);
    rd("R10 read masked", 3'd5, 8'h02);

    // R12 unmapped
    wr(3'd6, 8'hAA);
    wr(3'd7, 8'h55);
    check("R12 code", {8'h0, dacCode}, 32'h806621);
    check("R12 en", {29'h0, dacEnable}, 32'h2);
    rd("R12 read6", 3'd6, 8'h00);
    rd("R12 read7", 3'd7, 8'h00);

    // R9 transmit edge with all channels synced
    wr(3'd4, 8'hE0);
    rd("R9 sync read", 3'd4, 8'hE0);
    wr(3'd0, 8'h11);
    wr(3'd1, 8'h22);
    wr(3'd2, 8'h33);
    check("R8 synced ignore write", {8'h0, dacCode}, 32'h806621);
    txPwrDown = 1'b1;
    @(negedge clk);
    check("R9 edge1", {8'h0, dacCode}, 32'h806621);
    @(negedge clk);
    check("R9 edge2", {8'h0, dacCode}, 32'h806621);
    @(negedge clk);
    check("R9 edge3", {8'h0, dacCode}, 32'h332211);
    wr(3'd0, 8'h44);
    repeat (4) @(negedge clk);
    check("R9 held high", {8'h0, dacCode}, 32'h332211);
    txPwrDown = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 falling", {8'h0, dacCode}, 32'h332211);

    // R11 coincident update and edge: A synced, B not
    wr(3'd4, 8'h20);
    wr(3'd3, 8'h80);
    wr(3'd1, 8'h55);
    txPwrDown = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(3'd3, 8'h83);
    check("R11 coincide", {8'h0, dacCode}, 32'h335544);
    wr(3'd0, 8'h77);
    wr(3'd3, 8'h81);
    check("R8 synced ignores update", {8'h0, dacCode}, 32'h335544);
    txPwrDown = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule